// File: doc/BRIEF.md
# Motor Bridge Protection and Power-State Supervisor

This block decides, cycle by cycle, whether a single H-bridge power stage may be driven. It watches five asynchronous conditions: an active-low logic reset request, an active-low sleep request (modelled as a "stay awake" level), a raw indication from the per-FET analog current limiters, an over-temperature flag and a supply-undervoltage flag. From them it produces a bridge enable, an internal logic reset, an enable for the gate-drive charge pump and the low-voltage regulator, a ready indication and an active-low fault output that models an open-drain pin.

Each protection has its own recovery rule. An overcurrent that persists for a programmable number of clock cycles is latched, and it survives everything except a logic reset or a supply dip. An over-temperature shuts the bridge off only while it lasts. An undervoltage resets the internal logic outright. Leaving sleep starts a wake-up timer, and the bridge stays off until the timer runs out. The priority order is undervoltage, then reset, then sleep, then the fault conditions.

Top module: `mdg_guard`

## Requirements
- R1: While `logic_rst_n` is low or `supply_low` is high, `core_rst` is 1 at once, without waiting for a clock. During that time `pump_en`, `ready` and `bridge_en` are 0 and `fault_n` is 1, even when over-temperature is present. Once both inputs are inactive, `core_rst` falls after the second rising clock edge.
- R2: While the synchronized `stay_awake` is low, `pump_en`, `ready` and `bridge_en` are 0. `overtemp` and `ilim_hit` are ignored: they neither trip nor latch anything.
- R3: After the synchronized `stay_awake` goes high, `pump_en` is 1, while `ready` and `bridge_en` stay 0 for WAKE_CYCLES clock edges. Both become 1 on the edge after that, which is edge WAKE_CYCLES+2 counted from the raw input change.
- R4: When `ilim_hit` is seen high on OC_CYCLES consecutive synchronized samples while awake, the overcurrent fault latches: `bridge_en` goes to 0 and `fault_n` goes to 0 on edge OC_CYCLES+2 counted from the raw rise.
- R5: Any low sample of the synchronized `ilim_hit` before the count completes restarts the qualification. Two bursts of OC_CYCLES-1 cycles separated by one low cycle do not trip.
- R6: A latched overcurrent persists after `ilim_hit` falls, through sleep and wake-up, and while over-temperature comes and goes. It is cleared only by the internal logic reset (from `logic_rst_n` low or `supply_low` high).
- R7: While awake, a high synchronized `overtemp` forces `bridge_en` to 0 and `fault_n` to 0 two edges after the raw rise. Both recover two edges after the raw fall, with no wake-up delay.
- R8: `fault_n` is 0 only while a latched overcurrent exists or over-temperature is active while awake. In sleep it shows the latched overcurrent alone.
- R9: Every asynchronous input passes through two flops. A change of `stay_awake`, `ilim_hit` or `overtemp` is first visible at the outputs after the second rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running control clock |
| logic_rst_n | input | 1 | Asynchronous logic reset request, active low |
| stay_awake | input | 1 | Low requests sleep, high requests operation |
| ilim_hit | input | 1 | Raw indication that an analog current limiter is acting |
| overtemp | input | 1 | Raw die over-temperature flag |
| supply_low | input | 1 | Raw supply undervoltage flag |
| bridge_en | output | 1 | Bridge may be driven |
| core_rst | output | 1 | Internal logic reset, active high |
| pump_en | output | 1 | Charge pump and regulator enable |
| ready | output | 1 | Wake-up complete and not in reset or sleep |
| fault_n | output | 1 | Fault, active low; 0 pulls the open-drain line low, 1 releases it |

## Verification
The assertions take for granted that `supply_low` is high from time zero, so that `core_rst` is defined from the first edge. They also assume that every raw input holds each level for at least one full clock period, so that the two-flop synchronizers pass every change through. The stimulus changes inputs only just after a falling clock edge, at whole-cycle intervals. It powers up under undervoltage before releasing reset. It holds no input pulse shorter than a cycle, which keeps the counters in the checker and in the scoreboard aligned with the run lengths the design sees.

// File: rtl/mdg_pkg.sv
// Package: shared types and helpers for the bridge protection supervisor.
// Assumes nothing beyond IEEE 1800-2017 elaboration.
package mdg_pkg;

    // Operating mode of the supervisor, in priority order of decoding
    typedef enum logic [2:0] {
        MODE_OFF,    // internal logic held in reset
        MODE_SLEEP,  // low-power state, inputs ignored
        MODE_WAKE,   // awake, waiting for the wake-up timer
        MODE_TRIP,   // awake and ready, but a fault blocks the bridge
        MODE_RUN     // bridge may be driven
    } mode_t;

    // Width needed to hold the values 0..n
    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/mdg_rst_sync.sv
// Reset bridge: asserts its reset output at once when arst_n falls and
// releases it only after STAGES rising edges with arst_n high.
// Assumes STAGES >= 2.
module mdg_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst
);

    logic [STAGES-1:0] shift_q;

    // Shift ones in after release, clear everything on assertion
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            shift_q <= '0;
        end else begin
            shift_q <= {shift_q[STAGES-2:0], 1'b1};
        end
    end

    assign rst = ~shift_q[STAGES-1];

endmodule

// File: rtl/mdg_sync.sv
// Multi-bit level synchronizer: each bit passes through STAGES flops.
// Assumes the bits are independent levels held for at least one clock.
module mdg_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             clr,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First capture flop of the chain
            always_ff @(posedge clk or posedge clr) begin
                if (clr) stg_q[i] <= '0;
                else     stg_q[i] <= d;
            end
        end else begin : g_next
            // Further settling flops
            always_ff @(posedge clk or posedge clr) begin
                if (clr) stg_q[i] <= '0;
                else     stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/mdg_wake_timer.sv
// Wake-up delay: counts edges while go is high and flags done after LIMIT.
// Assumes go is already synchronized; rst is an asynchronous clear.
module mdg_wake_timer
    import mdg_pkg::*;
#(
    parameter int unsigned LIMIT = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic done
);

    localparam int unsigned CW = cnt_w(LIMIT);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    // Count up to the limit while awake, restart whenever asleep
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!go) begin
            cnt_q <= '0;
        end else if (cnt_q != LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = go && (cnt_q == LIM);

endmodule

// File: rtl/mdg_oc_qual.sv
// Overcurrent qualifier: latches a trip when the current-limit indication
// is seen on LIMIT consecutive samples; any gap restarts the count.
// Assumes hit is synchronized; only rst clears the latch.
module mdg_oc_qual
    import mdg_pkg::*;
#(
    parameter int unsigned LIMIT = 150
) (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    output logic trip
);

    localparam int unsigned CW = cnt_w(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] run_q;
    logic          trip_q;

    // Count consecutive samples, restarting on every low sample
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            run_q <= '0;
        end else if (!hit) begin
            run_q <= '0;
        end else if (run_q != LAST) begin
            run_q <= run_q + 1'b1;
        end
    end

    // Set the trip on the qualifying sample and hold it until reset
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            trip_q <= 1'b0;
        end else if (hit && (run_q == LAST)) begin
            trip_q <= 1'b1;
        end
    end

    assign trip = trip_q;

endmodule

// File: rtl/mdg_guard.sv
// Top: power-state and protection supervisor for one H-bridge.
// Priority: undervoltage, logic reset, sleep, then faults.
// Assumes raw inputs hold each level for at least one clock period.
module mdg_guard
    import mdg_pkg::*;
#(
    parameter int unsigned WAKE_CYCLES = 50000,
    parameter int unsigned OC_CYCLES   = 150,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic logic_rst_n,
    input  logic stay_awake,
    input  logic ilim_hit,
    input  logic overtemp,
    input  logic supply_low,
    output logic bridge_en,
    output logic core_rst,
    output logic pump_en,
    output logic ready,
    output logic fault_n
);

    logic       arst_n;
    logic [2:0] sync_q;
    logic       awake_s;
    logic       ilim_s;
    logic       hot_s;
    logic       woke;
    logic       oc_trip;
    logic       hot_active;
    logic       fault_any;
    mode_t      mode;

    // Undervoltage and reset request share one asynchronous reset path
    assign arst_n = logic_rst_n & ~supply_low;

    mdg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
        .clk    (clk),
        .arst_n (arst_n),
        .rst    (core_rst)
    );

    mdg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .clr (core_rst),
        .d   ({stay_awake, ilim_hit, overtemp}),
        .q   (sync_q)
    );

    assign awake_s = sync_q[2];
    assign ilim_s  = sync_q[1];
    assign hot_s   = sync_q[0];

    mdg_wake_timer #(.LIMIT(WAKE_CYCLES)) u_wake (
        .clk  (clk),
        .rst  (core_rst),
        .go   (awake_s),
        .done (woke)
    );

    mdg_oc_qual #(.LIMIT(OC_CYCLES)) u_oc (
        .clk  (clk),
        .rst  (core_rst),
        .hit  (ilim_s & awake_s),
        .trip (oc_trip)
    );

    assign hot_active = hot_s & awake_s;
    assign fault_any  = oc_trip | hot_active;

    // Decode the operating mode in priority order
    always_comb begin
        if (core_rst)       mode = MODE_OFF;
        else if (!awake_s)  mode = MODE_SLEEP;
        else if (!woke)     mode = MODE_WAKE;
        else if (fault_any) mode = MODE_TRIP;
        else                mode = MODE_RUN;
    end

    // Drive the enables and the fault line from the mode
    always_comb begin
        pump_en   = 1'b0;
        ready     = 1'b0;
        bridge_en = 1'b0;
        fault_n   = 1'b1;
        case (mode)
            MODE_OFF: begin
            end
            MODE_SLEEP: begin
                fault_n = ~oc_trip;
            end
            MODE_WAKE: begin
                pump_en = 1'b1;
                fault_n = ~fault_any;
            end
            MODE_TRIP: begin
                pump_en = 1'b1;
                ready   = 1'b1;
                fault_n = 1'b0;
            end
            MODE_RUN: begin
                pump_en   = 1'b1;
                ready     = 1'b1;
                bridge_en = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/mdg_guard_chk.sv
// Checker for mdg_guard: timing and priority properties, bound to the top.
// Assumes supply_low is asserted at time zero so core_rst is defined.
module mdg_guard_chk
    import mdg_pkg::*;
#(
    parameter int unsigned WAKE_CYCLES = 50000,
    parameter int unsigned OC_CYCLES   = 150
) (
    input logic clk,
    input logic core_rst,
    input logic awake_s,
    input logic ilim_s,
    input logic hot_s,
    input logic oc_trip,
    input logic pump_en,
    input logic ready,
    input logic bridge_en,
    input logic fault_n
);

    localparam int unsigned WW = cnt_w(WAKE_CYCLES);
    localparam int unsigned OW = cnt_w(OC_CYCLES);

    logic [WW-1:0] pump_run_q;
    logic [OW-1:0] ilim_run_q;

    // Edges for which pump_en has been high, saturating
    always_ff @(posedge clk or posedge core_rst) begin
        if (core_rst)                          pump_run_q <= '0;
        else if (!pump_en)                     pump_run_q <= '0;
        else if (pump_run_q != WW'(WAKE_CYCLES)) pump_run_q <= pump_run_q + 1'b1;
    end

    // Consecutive awake samples of the limiter indication, saturating
    always_ff @(posedge clk or posedge core_rst) begin
        if (core_rst)                        ilim_run_q <= '0;
        else if (!(ilim_s && awake_s))       ilim_run_q <= '0;
        else if (ilim_run_q != OW'(OC_CYCLES)) ilim_run_q <= ilim_run_q + 1'b1;
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        core_rst |-> (!pump_en && !ready && !bridge_en && fault_n));

    p_release_asleep_r1: assert property (@(posedge clk)
        $fell(core_rst) |-> !pump_en);

    p_sleep_off_r2: assert property (@(posedge clk) disable iff (core_rst)
        !awake_s |-> (!pump_en && !ready && !bridge_en));

    p_wake_delay_r3: assert property (@(posedge clk) disable iff (core_rst)
        $rose(ready) |-> (pump_run_q == WW'(WAKE_CYCLES)));

    p_ready_needs_pump_r3: assert property (@(posedge clk) disable iff (core_rst)
        ready |-> pump_en);

    p_trip_blocks_r4: assert property (@(posedge clk) disable iff (core_rst)
        oc_trip |-> (!bridge_en && !fault_n || !awake_s));

    p_trip_qualified_r5: assert property (@(posedge clk) disable iff (core_rst)
        $rose(oc_trip) |-> (ilim_run_q >= OW'(OC_CYCLES)));

    p_trip_held_r6: assert property (@(posedge clk) disable iff (core_rst)
        oc_trip |=> oc_trip);

    p_hot_blocks_r7: assert property (@(posedge clk) disable iff (core_rst)
        (hot_s && awake_s) |-> (!fault_n && !bridge_en));

    p_hot_resume_r7: assert property (@(posedge clk) disable iff (core_rst)
        (ready && !hot_s && !oc_trip) |-> bridge_en);

    p_fault_cause_r8: assert property (@(posedge clk) disable iff (core_rst)
        !fault_n |-> (oc_trip || (hot_s && awake_s)));

endmodule

bind mdg_guard mdg_guard_chk #(
    .WAKE_CYCLES (WAKE_CYCLES),
    .OC_CYCLES   (OC_CYCLES)
) u_chk (
    .clk       (clk),
    .core_rst  (core_rst),
    .awake_s   (awake_s),
    .ilim_s    (ilim_s),
    .hot_s     (hot_s),
    .oc_trip   (oc_trip),
    .pump_en   (pump_en),
    .ready     (ready),
    .bridge_en (bridge_en),
    .fault_n   (fault_n)
);

// File: tb/tb_mdg_guard.sv
// Scoreboard bench: the driver queues expected output vectors stamped with
// the edge count at which they must hold; a monitor compares at falling edges.
module tb_mdg_guard;

    localparam int unsigned WAKE = 20;
    localparam int unsigned OC   = 6;

    // Output vector order: {core_rst, pump_en, ready, bridge_en, fault_n}
    localparam logic [4:0] V_OFF   = 5'b10001;
    localparam logic [4:0] V_SLP   = 5'b00001;
    localparam logic [4:0] V_SLPF  = 5'b00000;
    localparam logic [4:0] V_WAK   = 5'b01001;
    localparam logic [4:0] V_WAKF  = 5'b01000;
    localparam logic [4:0] V_RUN   = 5'b01111;
    localparam logic [4:0] V_TRP   = 5'b01100;

    typedef struct {
        int unsigned at;
        logic [4:0]  exp;
        string       tag;
    } item_t;

    logic clk = 1'b0;
    logic logic_rst_n, stay_awake, ilim_hit, overtemp, supply_low;
    logic bridge_en, core_rst, pump_en, ready, fault_n;

    int unsigned cyc = 0;
    int          checks = 0;
    int          fails = 0;
    bit          done = 0;
    item_t       sb[$];

    mdg_guard #(.WAKE_CYCLES(WAKE), .OC_CYCLES(OC)) dut (
        .clk         (clk),
        .logic_rst_n (logic_rst_n),
        .stay_awake  (stay_awake),
        .ilim_hit    (ilim_hit),
        .overtemp    (overtemp),
        .supply_low  (supply_low),
        .bridge_en   (bridge_en),
        .core_rst    (core_rst),
        .pump_en     (pump_en),
        .ready       (ready),
        .fault_n     (fault_n)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop and compare every item due at this edge count
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at == cyc) begin
            logic [4:0] act;
            act = {core_rst, pump_en, ready, bridge_en, fault_n};
            checks++;
            if (act !== sb[0].exp) begin
                fails++;
                $display("FAIL %s: got %b expected %b (cycle %0d)",
                         sb[0].tag, act, sb[0].exp, cyc);
            end
            void'(sb.pop_front());
        end
    end

    // Driver helper: expect vector v after n more rising edges, then wait there
    task automatic chk_after(input int unsigned n, input logic [4:0] v, input string tag);
        item_t it;
        it.at  = cyc + n;
        it.exp = v;
        it.tag = tag;
        sb.push_back(it);
        repeat (n) @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic idle(input int unsigned n);
        repeat (n) @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    // Watchdog: an overrun counts as a failure and still prints the summary
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, got hang expected finish");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        supply_low  = 1'b1;
        logic_rst_n = 1'b0;
        stay_awake  = 1'b0;
        ilim_hit    = 1'b0;
        overtemp    = 1'b0;
        @(negedge clk); #1;
        chk_after(3, V_OFF, "R1 power-up under undervoltage");

        // Release reset while asleep
        supply_low = 1'b0; logic_rst_n = 1'b1;
        chk_after(1, V_OFF, "R1 reset still held after one edge");
        chk_after(1, V_SLP, "R1 released after second edge, R2 asleep");

        // Wake up
        stay_awake = 1'b1;
        chk_after(1, V_SLP, "R9 awake not yet visible");
        chk_after(1, V_WAK, "R9 R3 pump on after two edges");
        chk_after(WAKE - 1, V_WAK, "R3 still waiting at last delay edge");
        chk_after(1, V_RUN, "R3 ready after wake delay");

        // Faults ignored while asleep
        stay_awake = 1'b0;
        chk_after(2, V_SLP, "R2 back to sleep");
        ilim_hit = 1'b1; overtemp = 1'b1;
        chk_after(3 * OC, V_SLP, "R2 limiter and heat ignored in sleep");
        ilim_hit = 1'b0; overtemp = 1'b0; stay_awake = 1'b1;
        chk_after(WAKE + 2, V_RUN, "R2 nothing latched during sleep");

        // Self-clearing over-temperature
        overtemp = 1'b1;
        chk_after(1, V_RUN, "R9 heat not yet visible");
        chk_after(1, V_TRP, "R7 heat blocks bridge");
        idle(4);
        overtemp = 1'b0;
        chk_after(1, V_TRP, "R7 heat release not yet visible");
        chk_after(1, V_RUN, "R7 resumes without wake delay");

        // Interrupted bursts must not trip
        ilim_hit = 1'b1; idle(OC - 2);
        ilim_hit = 1'b0; idle(0);
        ilim_hit = 1'b1; idle(OC - 2);
        ilim_hit = 1'b0;
        chk_after(4, V_RUN, "R5 interrupted bursts do not trip");

        // Sustained limiter latches
        ilim_hit = 1'b1;
        chk_after(OC + 1, V_RUN, "R4 not tripped one edge early");
        chk_after(1, V_TRP, "R4 tripped at qualification edge");
        ilim_hit = 1'b0;
        chk_after(5, V_TRP, "R6 latched after limiter release");
        overtemp = 1'b1; idle(3);
        overtemp = 1'b0;
        chk_after(4, V_TRP, "R6 R8 latch survives heat pulse");

        // Through sleep and wake-up
        stay_awake = 1'b0;
        chk_after(2, V_SLPF, "R8 sleep shows latched fault");
        stay_awake = 1'b1;
        chk_after(WAKE + 1, V_WAKF, "R6 waking with latched fault");
        chk_after(1, V_TRP, "R6 ready but still tripped");

        // Clear via logic reset, with heat present (reset wins)
        overtemp = 1'b1;
        logic_rst_n = 1'b0;
        chk_after(1, V_OFF, "R1 reset wins over heat and latch");
        overtemp = 1'b0;
        logic_rst_n = 1'b1;
        chk_after(2, V_SLP, "R1 release resynchronizes awake");
        chk_after(1, V_SLP, "R9 awake resync first stage");
        chk_after(1, V_WAK, "R9 awake resync second stage");
        chk_after(WAKE - 1, V_WAK, "R3 delay restarts after reset");
        chk_after(1, V_RUN, "R6 latch cleared by logic reset");

        // Latch again, then clear via undervoltage during sleep
        ilim_hit = 1'b1;
        chk_after(OC + 2, V_TRP, "R4 trips again");
        ilim_hit = 1'b0; stay_awake = 1'b0;
        chk_after(2, V_SLPF, "R8 asleep with latch");
        supply_low = 1'b1;
        chk_after(1, V_OFF, "R1 undervoltage wins over sleep");
        supply_low = 1'b0; stay_awake = 1'b1;
        chk_after(4 + WAKE, V_RUN, "R6 latch cleared by undervoltage");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule